// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt of a real-time clock. It runs a free 16-bit counter that advances on every 32768 Hz tick enable and, when periodic interrupts are allowed, raises a one-clock interrupt pulse each time the count lands on a multiple of the selected power-of-two period. Together with the pulse it presents a status-bit set mask that the register file ORs into its status register.

The period is picked by a 4-bit rate code. A code n from 3 to 15 gives 2^(n-1) ticks. Codes 1 and 2 do not give the two fastest rates; they are slowed to 256 and 512 ticks. Code 0 turns the output off, as do a low enable bit and a high external inhibit. Because every pulse sits on a multiple of the period of the shared count, changing the rate or re-enabling never starts a fresh period from the moment of the change.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset `irq_pulse` is 0, `stat_set` is 0x00 and the internal tick count is 0.
- R2: A rate code of 0 produces no pulse, whatever the other inputs.
- R3: With `per_en` low no pulse is produced.
- R4: With `inhibit` high no pulse is produced.
- R5: For codes 3 to 15 the period is 2^(code-1) ticks: a pulse follows a tick exactly when the count after that tick is a multiple of the period.
- R6: Code 1 gives a period of 256 ticks and code 2 a period of 512 ticks, with the same alignment rule as R5.
- R7: A pulse lasts one clock cycle and appears only in the cycle after a clock edge on which `tick_32k` was high; the code, enable and inhibit values sampled on that edge decide it.
- R8: `stat_set` is 0xC0 (bits 7 and 6) in exactly the cycles where `irq_pulse` is high, and 0x00 otherwise.
- R9: The count advances on every tick regardless of code, enable or inhibit, so after enabling, the first pulse falls on the next period multiple of the running count rather than one period after the enable.
- R10: The count is 16 bits wide and wraps from 0xFFFF to 0x0000; the tick that wraps it is a multiple of every period and pulses when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| rate_code | input | 4 | Rate select code, 0 turns the output off |
| per_en | input | 1 | Periodic interrupt enable |
| inhibit | input | 1 | External suppression of periodic interrupts |
| irq_pulse | output | 1 | One-cycle periodic interrupt request |
| stat_set | output | 8 | Status bits to set, 0xC0 during a pulse |

## Verification
A corrupted tick count is never visible directly, but it moves every later pulse off the period grid, so at short periods a wrong count shows up within four ticks as a pulse at the wrong tick or a missing one. A wrong period decode for a code shows within one period of that code, and a wrong remap of codes 1 and 2 within 512 ticks. A fault in the wrap shows at the single tick where the count returns to zero.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W     = 16,
  parameter int CODE_W    = 4,
  parameter int SLOW_OFS  = 7,
  parameter logic [7:0] FLAG_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              inhibit,
  output logic              irq_pulse,
  output logic [7:0]        stat_set
);

  localparam int EXP_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [EXP_W-1:0] exp_sel;
  logic [CNT_W-1:0] mask;
  logic             armed;
  logic             hit;
  logic [7:0]       flags_q;

  assign cnt_nxt = cnt_q + 1'b1;
  assign exp_sel = (rate_code <= CODE_W'(2)) ? EXP_W'(rate_code + SLOW_OFS)
                                             : EXP_W'(rate_code - 1'b1);
  assign mask    = (CNT_W'(1) << exp_sel) - 1'b1;
  assign armed   = (rate_code != '0) && per_en && !inhibit;
  assign hit     = tick_32k && armed && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      irq_pulse <= 1'b0;
      flags_q   <= '0;
    end else begin
      if (tick_32k) cnt_q <= cnt_nxt;
      irq_pulse <= hit;
      flags_q   <= hit ? FLAG_MASK : 8'h00;
    end
  end

  assign stat_set = flags_q;

  a_r2_code_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(rate_code) != '0);
  a_r3_enable_required: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(per_en));
  a_r4_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(inhibit));
  a_r7_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick_32k));
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r8_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set == (irq_pulse ? FLAG_MASK : 8'h00));
  a_r5_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(rate_code) >= 4'd3) |-> cnt_q[1:0] == 2'b00);
  a_r6_slow_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(rate_code) == 4'd1) |-> cnt_q[7:0] == 8'h00);

endmodule

// File: tb/tb_periodic_rate_gen.sv
module tb_periodic_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       inhibit = 1'b0;
  logic       irq_pulse;
  logic [7:0] stat_set;

  int tests = 0;
  int fails = 0;
  int unsigned mcnt = 0;
  logic exp_irq = 1'b0;
  string exp_tag = "R1";
  bit done = 1'b0;
  int pulses_seen = 0;

  periodic_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
    .per_en(per_en), .inhibit(inhibit), .irq_pulse(irq_pulse), .stat_set(stat_set)
  );

  always #2.5 clk = ~clk;

  function automatic int unsigned period_of(input logic [3:0] c);
    if (c == 4'd1) return 256;
    if (c == 4'd2) return 512;
    return 1 << (c - 1);
  endfunction

  function automatic string tag_of(input logic t, input logic [3:0] c,
                                   input logic e, input logic i, input logic p);
    if (!t) return "R7";
    if (c == 0) return "R2";
    if (!e) return "R3";
    if (i) return "R4";
    if (p) return (c <= 2) ? "R6" : "R5";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h (count %0d)", tag, act, exp, mcnt);
    end
  endtask

  // sample results of the last edge, then drive the next inputs
  task automatic step(input logic t, input logic [3:0] c, input logic e, input logic i);
    logic p;
    @(negedge clk);
    check(exp_tag, {7'd0, irq_pulse}, {7'd0, exp_irq});
    check("R8", stat_set, exp_irq ? 8'hC0 : 8'h00);
    if (irq_pulse) pulses_seen++;
    tick_32k = t; rate_code = c; per_en = e; inhibit = i;
    p = 1'b0;
    if (t) begin
      mcnt = (mcnt + 1) & 32'hFFFF;
      p = (mcnt % period_of(c)) == 0;
    end
    exp_irq = t && c != 0 && e && !i && p;
    exp_tag = (mcnt == 0 && t) ? "R10" : tag_of(t, c, e, i, p);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", {7'd0, irq_pulse}, 8'd0);
    check("R1", stat_set, 8'h00);
    // R9: count runs while disabled; first pulse on grid, not one period after enable
    for (int k = 0; k < 5; k++) step(1'b1, 4'd3, 1'b0, 1'b0);
    pulses_seen = 0;
    for (int k = 0; k < 3; k++) step(1'b1, 4'd3, 1'b1, 1'b0);
    step(1'b0, 4'd3, 1'b1, 1'b0);
    tests++;
    if (pulses_seen != 1) begin
      fails++;
      $display("FAIL R9: actual %0d pulses expected 1 by count 8", pulses_seen);
    end
    // R6: slow codes, directed
    for (int k = 0; k < 600; k++) step(1'b1, 4'd1, 1'b1, 1'b0);
    for (int k = 0; k < 1100; k++) step(1'b1, 4'd2, 1'b1, 1'b0);
    // constrained random segments
    for (int s = 0; s < 60; s++) begin
      logic [3:0] c;
      logic e, i;
      int dens;
      c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) c = 4'($urandom_range(0, 6));
      e = ($urandom_range(0, 4) != 0);
      i = ($urandom_range(0, 5) == 0);
      dens = $urandom_range(1, 4);
      for (int k = 0; k < 300; k++)
        step(($urandom_range(1, dens) == 1), c, e, i);
    end
    // R10: run through the wrap with the slowest rate
    for (int k = 0; k < 70000; k++) step(1'b1, 4'd15, 1'b1, 1'b0);
    step(1'b0, 4'd15, 1'b1, 1'b0);
    step(1'b0, 4'd15, 1'b1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule